// File: doc/BRIEF.md
# Load/Store Effective-Address and Lane Unit

This block sits between the instruction decode stage of a 32-bit integer core and a simple synchronous data memory. Each request carries a decoded memory access: direction, operand size, extension mode, whether the base register is updated, and whether the second operand is an index register or a 16-bit displacement. The block forms the effective address, places store data on the correct big-endian byte lanes, and drives the memory port. It then picks the returned bytes for a load and extends them to a full register.

The block has two register-file write ports, and each one has its own strobe. The load-result port retires the extended data to the destination register. The write-back port returns the effective address to the base register when the update option asks for it. The rule that allows the update is different for loads and stores. A load whose register numbers break its rule still reads memory, but it raises an invalid-form flag instead of updating the base.

Requests come in on a valid/ready interface. Ready is held high, so back-pressure never occurs. A request is taken on every clock edge where valid is high, and the pipeline accepts one access per cycle with no bubbles. The memory must return read data on the clock edge after it samples an enabled read. The register file must take both write ports in any cycle, because they never stall.

Top module: `ldst_agu`

## Requirements
- R1: In offset mode (`req_indexed`=0), the effective address is the base plus `req_disp` sign-extended to 32 bits, wrapping modulo 2^32.
- R2: In indexed mode (`req_indexed`=1), the effective address is the base plus `req_rb_val`.
- R3: When `req_ra_idx` is 0, the base is the constant 0 and `req_ra_val` is ignored.
- R4: On the clock edge after acceptance, `mem_en` rises for one cycle and `mem_addr` shows the effective address with its two low bits cleared. For a store, `mem_we` is also high, which completes the store at that single edge.
- R5: `mem_be[i]` enables `mem_wdata[8i+7:8i]`, and byte offset 0 is bits 31:24 (big-endian). `req_size` is encoded 00 byte, 01 halfword, 10 or 11 word. A byte at offset k enables only bit 3-k. A halfword enables 4'b1100 when address bit 1 is 0 and 4'b0011 when it is 1. A word enables 4'b1111.
- R6: For a store, `mem_wdata` holds the low byte of `req_sdata` copied four times for a byte, the low halfword copied twice for a halfword, or all of `req_sdata` for a word.
- R7: A byte load returns the addressed byte in bits 7:0 with every higher bit zero, whatever the value of `req_signed`.
- R8: A halfword load returns the addressed halfword in bits 15:0. It is sign-extended when `req_signed`=1 and zero-extended when 0. A word load returns the full memory word.
- R9: A load result appears on `ld_data` with `ld_valid` high and `ld_idx` equal to `req_rd_idx` in the second cycle after acceptance, so the register file captures it at the second edge.
- R10: A load with `req_update`=1 raises `wb_valid`, with `wb_idx`=`req_ra_idx` and `wb_data` equal to the effective address, in the same cycle as `mem_en`. This happens only when `req_ra_idx` is non-zero and differs from `req_rd_idx`.
- R11: A store with `req_update`=1 writes the effective address back whenever `req_ra_idx` is non-zero, even when it equals the source register number given on `req_rd_idx`.
- R12: A load with `req_update`=1 whose `req_ra_idx` is 0 or equals `req_rd_idx` pulses `bad_form` in the `mem_en` cycle with no write-back, and still performs the load.
- R13: `req_ready` is always high. Back-to-back requests on consecutive cycles each produce their own memory access and result, in order, one cycle apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_store | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_signed | input | 1 | Sign-extend a halfword load |
| req_update | input | 1 | Write effective address back to base register |
| req_indexed | input | 1 | Use index register instead of displacement |
| req_ra_idx | input | 5 | Base register number (0 selects constant zero) |
| req_rd_idx | input | 5 | Load destination or store source register number |
| req_ra_val | input | 32 | Base register value |
| req_rb_val | input | 32 | Index register value |
| req_disp | input | 16 | Signed displacement |
| req_sdata | input | 32 | Store data (right-justified) |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Read data, one edge after a read |
| ld_valid | output | 1 | Load result strobe |
| ld_idx | output | 5 | Load destination register |
| ld_data | output | 32 | Extended load result |
| wb_valid | output | 1 | Base write-back strobe |
| wb_idx | output | 5 | Base register to update |
| wb_data | output | 32 | Effective address for write-back |
| bad_form | output | 1 | Invalid update form on a load |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path, a 16-bit displacement and 5-bit register numbers. With these values a displacement of 0xFFF8 tests the sign extension, and register 0 and equal base/destination numbers test the update rules at their edges. The four byte lanes of a 32-bit word let every byte offset and both halfword positions be checked against a small memory model in the bench. A byte store followed by a halfword store into the same word, then read back as a word, shows that partial writes leave the other lanes untouched.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRSV = 2'b11
  } acc_size_e;
endpackage

// File: rtl/ldst_ea.sv
module ldst_ea #(
  parameter int XLEN   = 32,
  parameter int DISP_W = 16,
  parameter int RIDX_W = 5
) (
  input  logic              is_store,
  input  logic              update,
  input  logic              indexed,
  input  logic [RIDX_W-1:0] ra_idx,
  input  logic [RIDX_W-1:0] rd_idx,
  input  logic [XLEN-1:0]   ra_val,
  input  logic [XLEN-1:0]   rb_val,
  input  logic [DISP_W-1:0] disp,
  output logic [XLEN-1:0]   ea,
  output logic              wb_en,
  output logic              bad
);
  localparam int EXT_W = XLEN - DISP_W;

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offs;
  logic            ra_zero;
  logic            ra_is_rd;

  // base of zero when register 0 is named
  assign ra_zero  = (ra_idx == '0);
  assign ra_is_rd = (ra_idx == rd_idx);
  assign base     = ra_zero ? '0 : ra_val;
  assign offs     = indexed ? rb_val : {{EXT_W{disp[DISP_W-1]}}, disp};
  assign ea       = base + offs;

  // loads may not update register 0 or their own destination; stores only avoid 0
  assign wb_en = update && !ra_zero && (is_store || !ra_is_rd);
  assign bad   = update && !is_store && (ra_zero || ra_is_rd);
endmodule

// File: rtl/ldst_store_lane.sv
module ldst_store_lane
  import ldst_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int NB    = XLEN / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic [XLEN-1:0]   sdata,
  output logic [NB-1:0]     be,
  output logic [XLEN-1:0]   wdata
);
  always_comb begin
    int boff;
    int hoff;
    boff  = int'(off);
    hoff  = boff >> 1;
    be    = '0;
    wdata = sdata;
    unique case (size)
      SZ_BYTE: begin
        wdata = {NB{sdata[7:0]}};
        for (int i = 0; i < NB; i++)
          if (i == NB - 1 - boff) be[i] = 1'b1;
      end
      SZ_HALF: begin
        wdata = {(NB/2){sdata[15:0]}};
        for (int i = 0; i < NB; i++)
          if ((i == NB - 1 - 2*hoff) || (i == NB - 2 - 2*hoff)) be[i] = 1'b1;
      end
      default: begin
        be    = '1;
        wdata = sdata;
      end
    endcase
  end
endmodule

// File: rtl/ldst_load_extract.sv
module ldst_load_extract
  import ldst_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int NB    = XLEN / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  acc_size_e         size,
  input  logic              sign,
  input  logic [OFF_W-1:0]  off,
  input  logic [XLEN-1:0]   rdata,
  output logic [XLEN-1:0]   data
);
  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  always_comb begin
    int boff;
    int hoff;
    boff  = int'(off);
    hoff  = boff >> 1;
    sel_b = '0;
    sel_h = '0;
    for (int i = 0; i < NB; i++)
      if (i == NB - 1 - boff) sel_b = rdata[i*8 +: 8];
    for (int h = 0; h < NB/2; h++)
      if (h == NB/2 - 1 - hoff) sel_h = rdata[h*16 +: 16];
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: data = {{(XLEN-8){1'b0}}, sel_b};
      SZ_HALF: data = {{(XLEN-16){sign & sel_h[15]}}, sel_h};
      default: data = rdata;
    endcase
  end
endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
  import ldst_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int DISP_W = 16,
  parameter int RIDX_W = 5,
  localparam int NB    = XLEN / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic              req_update,
  input  logic              req_indexed,
  input  logic [RIDX_W-1:0] req_ra_idx,
  input  logic [RIDX_W-1:0] req_rd_idx,
  input  logic [XLEN-1:0]   req_ra_val,
  input  logic [XLEN-1:0]   req_rb_val,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [XLEN-1:0]   req_sdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [NB-1:0]     mem_be,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              ld_valid,
  output logic [RIDX_W-1:0] ld_idx,
  output logic [XLEN-1:0]   ld_data,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]   wb_data,
  output logic              bad_form
);
  acc_size_e       c_size;
  logic [XLEN-1:0] c_ea;
  logic            c_wb_en;
  logic            c_bad;
  logic [NB-1:0]   c_be;
  logic [XLEN-1:0] c_wdata;
  logic            fire;

  assign req_ready = 1'b1;
  assign fire      = req_valid && req_ready;
  assign c_size    = acc_size_e'(req_size);

  ldst_ea #(.XLEN(XLEN), .DISP_W(DISP_W), .RIDX_W(RIDX_W)) u_ea (
    .is_store (req_store),
    .update   (req_update),
    .indexed  (req_indexed),
    .ra_idx   (req_ra_idx),
    .rd_idx   (req_rd_idx),
    .ra_val   (req_ra_val),
    .rb_val   (req_rb_val),
    .disp     (req_disp),
    .ea       (c_ea),
    .wb_en    (c_wb_en),
    .bad      (c_bad)
  );

  ldst_store_lane #(.XLEN(XLEN)) u_lane (
    .size  (c_size),
    .off   (c_ea[OFF_W-1:0]),
    .sdata (req_sdata),
    .be    (c_be),
    .wdata (c_wdata)
  );

  // stage 1: memory access and base write-back
  logic              s1_valid;
  logic              s1_store;
  logic [XLEN-1:0]   s1_ea;
  logic [NB-1:0]     s1_be;
  logic [XLEN-1:0]   s1_wdata;
  acc_size_e         s1_size;
  logic              s1_sign;
  logic [RIDX_W-1:0] s1_ra;
  logic [RIDX_W-1:0] s1_rd;
  logic              s1_wb_en;
  logic              s1_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_store <= 1'b0;
      s1_ea    <= '0;
      s1_be    <= '0;
      s1_wdata <= '0;
      s1_size  <= SZ_BYTE;
      s1_sign  <= 1'b0;
      s1_ra    <= '0;
      s1_rd    <= '0;
      s1_wb_en <= 1'b0;
      s1_bad   <= 1'b0;
    end else begin
      s1_valid <= fire;
      s1_store <= req_store;
      s1_ea    <= c_ea;
      s1_be    <= c_be;
      s1_wdata <= c_wdata;
      s1_size  <= c_size;
      s1_sign  <= req_signed;
      s1_ra    <= req_ra_idx;
      s1_rd    <= req_rd_idx;
      s1_wb_en <= fire && c_wb_en;
      s1_bad   <= fire && c_bad;
    end
  end

  assign mem_en    = s1_valid;
  assign mem_we    = s1_valid && s1_store;
  assign mem_addr  = {s1_ea[XLEN-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_be    = s1_be;
  assign mem_wdata = s1_wdata;
  assign wb_valid  = s1_wb_en;
  assign wb_idx    = s1_ra;
  assign wb_data   = s1_ea;
  assign bad_form  = s1_bad;

  // stage 2: load data returns from memory
  logic              s2_valid;
  acc_size_e         s2_size;
  logic              s2_sign;
  logic [OFF_W-1:0]  s2_off;
  logic [RIDX_W-1:0] s2_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_size  <= SZ_BYTE;
      s2_sign  <= 1'b0;
      s2_off   <= '0;
      s2_rd    <= '0;
    end else begin
      s2_valid <= s1_valid && !s1_store;
      s2_size  <= s1_size;
      s2_sign  <= s1_sign;
      s2_off   <= s1_ea[OFF_W-1:0];
      s2_rd    <= s1_rd;
    end
  end

  ldst_load_extract #(.XLEN(XLEN)) u_ext (
    .size  (s2_size),
    .sign  (s2_sign),
    .off   (s2_off),
    .rdata (mem_rdata),
    .data  (ld_data)
  );

  assign ld_valid = s2_valid;
  assign ld_idx   = s2_rd;

  // R4: a store reaches the memory port one edge after acceptance
  p_store_one_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_store) |=> (mem_en && mem_we));

  // R9: a load result follows two edges after acceptance
  p_load_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_store) |=> ##1 ld_valid);

  // R10: register 0 is never the write-back target
  p_wb_not_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_idx != '0));

  // R12: an invalid form blocks write-back but keeps the read
  p_bad_no_wb_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bad_form |-> (!wb_valid && mem_en && !mem_we));

  // R5: a byte access uses exactly one lane
  p_byte_one_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && s1_size == SZ_BYTE) |-> ($countones(mem_be) == 1));
endmodule

// File: tb/ldst_agu_tb.sv
module ldst_agu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic        req_signed = 1'b0;
  logic        req_update = 1'b0;
  logic        req_indexed = 1'b0;
  logic [4:0]  req_ra_idx = '0;
  logic [4:0]  req_rd_idx = '0;
  logic [31:0] req_ra_val = '0;
  logic [31:0] req_rb_val = '0;
  logic [15:0] req_disp = '0;
  logic [31:0] req_sdata = '0;
  logic        mem_en, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata = '0;
  logic        ld_valid, wb_valid, bad_form;
  logic [4:0]  ld_idx, wb_idx;
  logic [31:0] ld_data, wb_data;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ldst_agu u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_size(req_size), .req_signed(req_signed),
    .req_update(req_update), .req_indexed(req_indexed), .req_ra_idx(req_ra_idx),
    .req_rd_idx(req_rd_idx), .req_ra_val(req_ra_val), .req_rb_val(req_rb_val),
    .req_disp(req_disp), .req_sdata(req_sdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_data(ld_data), .wb_valid(wb_valid),
    .wb_idx(wb_idx), .wb_data(wb_data), .bad_form(bad_form)
  );

  // small synchronous memory model
  logic [31:0] mem [0:63];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[7:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[7:2]];
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one request; returns at the negedge where stage 1 outputs are visible
  task automatic issue(input logic st, input logic [1:0] sz, input logic sg,
                       input logic up, input logic ix, input logic [4:0] ra,
                       input logic [4:0] rd, input logic [31:0] rav,
                       input logic [31:0] rbv, input logic [15:0] dsp,
                       input logic [31:0] sd);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; req_signed = sg;
    req_update = up; req_indexed = ix; req_ra_idx = ra; req_rd_idx = rd;
    req_ra_val = rav; req_rb_val = rbv; req_disp = dsp; req_sdata = sd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R13 ready", {31'b0, req_ready}, 32'd1);
    check("R4 idle mem_en", {31'b0, mem_en}, 32'd0);
    check("R9 idle ld_valid", {31'b0, ld_valid}, 32'd0);
    check("R10 idle wb_valid", {31'b0, wb_valid}, 32'd0);
    check("R12 idle bad_form", {31'b0, bad_form}, 32'd0);
  endtask

  task automatic t_offset;
    issue(1, 2'b10, 0, 0, 0, 5'd3, 5'd9, 32'h0000_0100, 32'h0, 16'hFFF8, 32'hCAFE_F00D);
    check("R1 negative disp addr", mem_addr, 32'h0000_00F8);
    check("R4 store we", {30'b0, mem_en, mem_we}, 32'd3);
    check("R5 word be", {28'b0, mem_be}, 32'hF);
    check("R6 word wdata", mem_wdata, 32'hCAFE_F00D);
    @(negedge clk);
    check("R4 one-cycle strobe", {31'b0, mem_en}, 32'd0);
  endtask

  task automatic t_indexed;
    issue(1, 2'b10, 0, 1, 1, 5'd4, 5'd4, 32'h1000_0000, 32'h34, 16'hFFFF, 32'h1);
    check("R2 indexed addr", mem_addr, 32'h1000_0034);
    check("R11 store wb ra==rs", {31'b0, wb_valid}, 32'd1);
    check("R11 wb idx", {27'b0, wb_idx}, 32'd4);
    check("R11 wb data", wb_data, 32'h1000_0034);
  endtask

  task automatic t_zero_base;
    issue(1, 2'b10, 0, 1, 0, 5'd0, 5'd2, 32'hDEAD_0000, 32'h0, 16'h0040, 32'h7);
    check("R3 zero base addr", mem_addr, 32'h0000_0040);
    check("R11 no wb to r0", {31'b0, wb_valid}, 32'd0);
  endtask

  task automatic t_store_lanes;
    issue(1, 2'b00, 0, 0, 0, 5'd1, 5'd2, 32'h20, 32'h0, 16'h0001, 32'h1234_56AB);
    check("R5 byte off1 be", {28'b0, mem_be}, 32'b0100);
    check("R6 byte replicate", mem_wdata, 32'hABAB_ABAB);
    check("R4 byte aligned addr", mem_addr, 32'h20);
    issue(1, 2'b01, 0, 0, 0, 5'd1, 5'd2, 32'h20, 32'h0, 16'h0002, 32'h1234_5678);
    check("R5 half off2 be", {28'b0, mem_be}, 32'b0011);
    check("R6 half replicate", mem_wdata, 32'h5678_5678);
    issue(1, 2'b00, 0, 0, 0, 5'd1, 5'd2, 32'h30, 32'h0, 16'h0003, 32'h99);
    check("R5 byte off3 be", {28'b0, mem_be}, 32'b0001);
    issue(1, 2'b01, 0, 0, 0, 5'd1, 5'd2, 32'h30, 32'h0, 16'h0000, 32'h1);
    check("R5 half off0 be", {28'b0, mem_be}, 32'b1100);
    // read back the word built from a byte and a halfword store
    issue(0, 2'b10, 0, 0, 0, 5'd1, 5'd8, 32'h20, 32'h0, 16'h0000, 32'h0);
    @(negedge clk);
    check("R5 merged lanes", ld_data, 32'h00AB_5678);
  endtask

  task automatic t_load_byte;
    issue(0, 2'b00, 1, 0, 0, 5'd1, 5'd11, 32'h08, 32'h0, 16'h0000, 32'h0);
    check("R4 load no we", {30'b0, mem_en, mem_we}, 32'd2);
    check("R9 not yet valid", {31'b0, ld_valid}, 32'd0);
    @(negedge clk);
    check("R9 ld_valid", {31'b0, ld_valid}, 32'd1);
    check("R9 ld_idx", {27'b0, ld_idx}, 32'd11);
    check("R7 byte off0 zext", ld_data, 32'h0000_0089);
    issue(0, 2'b00, 0, 0, 0, 5'd1, 5'd12, 32'h08, 32'h0, 16'h0002, 32'h0);
    @(negedge clk);
    check("R7 byte off2", ld_data, 32'h0000_00CD);
    @(negedge clk);
    check("R9 one-cycle result", {31'b0, ld_valid}, 32'd0);
  endtask

  task automatic t_load_half;
    issue(0, 2'b01, 1, 0, 0, 5'd1, 5'd3, 32'h08, 32'h0, 16'h0000, 32'h0);
    @(negedge clk);
    check("R8 half off0 sext", ld_data, 32'hFFFF_89AB);
    issue(0, 2'b01, 0, 0, 0, 5'd1, 5'd3, 32'h08, 32'h0, 16'h0000, 32'h0);
    @(negedge clk);
    check("R8 half off0 zext", ld_data, 32'h0000_89AB);
    issue(0, 2'b01, 1, 0, 0, 5'd1, 5'd3, 32'h08, 32'h0, 16'h0002, 32'h0);
    @(negedge clk);
    check("R8 half off2 sext", ld_data, 32'hFFFF_CDEF);
    issue(0, 2'b01, 1, 0, 0, 5'd1, 5'd3, 32'h0C, 32'h0, 16'h0002, 32'h0);
    @(negedge clk);
    check("R8 half positive sext", ld_data, 32'h0000_1234);
    issue(0, 2'b10, 1, 0, 0, 5'd1, 5'd3, 32'h08, 32'h0, 16'h0000, 32'h0);
    @(negedge clk);
    check("R8 word", ld_data, 32'h89AB_CDEF);
  endtask

  task automatic t_load_update;
    issue(0, 2'b10, 0, 1, 0, 5'd5, 5'd6, 32'h04, 32'h0, 16'h0004, 32'h0);
    check("R10 wb_valid", {31'b0, wb_valid}, 32'd1);
    check("R10 wb_idx", {27'b0, wb_idx}, 32'd5);
    check("R10 wb_data", wb_data, 32'h08);
    check("R12 no flag", {31'b0, bad_form}, 32'd0);
    @(negedge clk);
    check("R10 load data", ld_data, 32'h89AB_CDEF);
    issue(0, 2'b10, 0, 1, 0, 5'd6, 5'd6, 32'h04, 32'h0, 16'h0004, 32'h0);
    check("R10 ra==rd no wb", {31'b0, wb_valid}, 32'd0);
    check("R12 ra==rd flag", {31'b0, bad_form}, 32'd1);
    check("R12 load still issued", {31'b0, mem_en}, 32'd1);
    @(negedge clk);
    check("R12 load still returns", {31'b0, ld_valid}, 32'd1);
    check("R12 load data", ld_data, 32'h89AB_CDEF);
    issue(0, 2'b10, 0, 1, 0, 5'd0, 5'd6, 32'hFFFF_FFFF, 32'h0, 16'h0008, 32'h0);
    check("R12 ra==0 flag", {31'b0, bad_form}, 32'd1);
    check("R10 ra==0 no wb", {31'b0, wb_valid}, 32'd0);
    @(negedge clk);
    check("R3 ra==0 load data", ld_data, 32'h89AB_CDEF);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b0; req_size = 2'b10; req_update = 1'b0;
    req_indexed = 1'b0; req_ra_idx = 5'd1; req_rd_idx = 5'd20;
    req_ra_val = 32'h08; req_disp = 16'h0;
    @(negedge clk);
    check("R13 ready under load", {31'b0, req_ready}, 32'd1);
    check("R13 first addr", mem_addr, 32'h08);
    req_rd_idx = 5'd21; req_ra_val = 32'h100; req_disp = 16'hFFF8;
    @(negedge clk);
    req_valid = 1'b0;
    check("R13 second addr", mem_addr, 32'hF8);
    check("R13 first result", ld_data, 32'h89AB_CDEF);
    check("R13 first idx", {27'b0, ld_idx}, 32'd20);
    @(negedge clk);
    check("R13 second result", ld_data, 32'hCAFE_F00D);
    check("R13 second idx", {27'b0, ld_idx}, 32'd21);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[2] = 32'h89AB_CDEF;
    mem[3] = 32'h5555_1234;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_offset();
    t_indexed();
    t_zero_base();
    t_store_lanes();
    t_load_byte();
    t_load_half();
    t_load_update();
    t_back_to_back();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule